// File: doc/BRIEF.md
# Page Program Load Buffer

This block gathers the data loads that follow a page-program command and hands a complete page to a programming engine. When the command is accepted, the page image is refilled with the erased value and the byte/word width is fixed. Each load then arrives as two strobes. The address is taken on the write falling strobe, and the data is taken on the write rising strobe. Loads may land at any location of one aligned page, in any order, and each one patches the image.

Loading has no closing command. After every data strobe the block counts microsecond ticks. If no new write falling strobe appears before the inactivity limit, the block emits a one-cycle start pulse and stops accepting loads. The page image and the page base address stay on the outputs for the engine to use until the next command arms the block again.

Top module: `page_load_buffer`

## Requirements
- R1: After reset the page image is all FFh, the page base is zero and no start pulse is issued.
- R2: In byte mode, wrAddr[6:0] selects the byte (bit 0 is the lowest byte-address bit). Only wrData[7:0] is stored, and wrData[15:8] is ignored.
- R3: In word mode, wrAddr[6:1] selects word w and wrAddr[0] is ignored. wrData[7:0] goes to image byte 2w and wrData[15:8] goes to image byte 2w+1. Image byte n occupies pageImage[8n+7:8n].
- R4: An armStart refills the whole image with FFh. Loads may come in any order, and locations that are never loaded stay FFh.
- R5: The first load after arming sets pageBase to wrAddr[20:7]. Any later load whose wrAddr[20:7] differs from pageBase writes nothing and leaves pageBase unchanged.
- R6: progStart is high for exactly one cycle. It rises in the cycle after the TIMEOUT_US-th usTick counted since the last data strobe, provided no write falling strobe came in between. After that, strobes change nothing until the next armStart.
- R7: A write falling strobe cancels the running window, even when it falls in the same cycle as the final tick. The next data strobe starts a new full window.
- R8: After armStart and before the first load, no start pulse is issued, however many ticks pass.
- R9: The address is the wrAddr value in the falling-strobe cycle and the data is the wrData value in the rising-strobe cycle. The width mode is armByteMode in the armStart cycle, and later changes to armByteMode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armStart | input | 1 | Page-program command accepted |
| armByteMode | input | 1 | 1 = byte loads, 0 = word loads; sampled with armStart |
| wrFall | input | 1 | Write falling strobe; latches the address |
| wrRise | input | 1 | Write rising strobe; latches the data |
| wrAddr | input | 21 | Byte-granular address; bit 0 is the lowest byte-address bit |
| wrData | input | 16 | Load data |
| usTick | input | 1 | One-cycle pulse per microsecond |
| pageImage | output | 1024 | Page image; byte n is bits [8n+7:8n] |
| pageBase | output | 14 | Page address of the first accepted load |
| progStart | output | 1 | One-cycle request to program the page |

## Verification
The timeout can expire and a new load can begin in the same cycle: the final usTick of the window and a write falling strobe then share one clock edge. The bench lets exactly TIMEOUT_US-1 ticks pass after a data strobe, then raises the last tick and wrFall together. It judges the outcome from the start-pulse count, which must not move. It then completes that load and requires a fresh full window before the single pulse appears.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic {ST_IDLE, ST_LOAD} pgbuf_state_t;

  typedef struct packed {
    logic clearAll;     // refill image, forget page base
    logic captureAddr;  // latch load address
    logic commitData;   // write load data at latched address
  } pgbuf_ctl_t;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int TIMEOUT_US = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       armStart,
  input  logic       wrFall,
  input  logic       wrRise,
  input  logic       usTick,
  output pgbuf_ctl_t ctl,
  output logic       progStart
);
  localparam int CNT_W = $clog2(TIMEOUT_US + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_US - 1);

  pgbuf_state_t     state;
  logic             winRun;
  logic             addrHeld;
  logic [CNT_W-1:0] tickCnt;

  always_comb begin
    ctl.clearAll    = armStart;
    ctl.captureAddr = (state == ST_LOAD) && !armStart && wrFall;
    ctl.commitData  = (state == ST_LOAD) && !armStart && !wrFall && wrRise && addrHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      winRun    <= 1'b0;
      addrHeld  <= 1'b0;
      tickCnt   <= '0;
      progStart <= 1'b0;
    end else begin
      progStart <= 1'b0;
      if (armStart) begin
        state    <= ST_LOAD;
        winRun   <= 1'b0;
        addrHeld <= 1'b0;
        tickCnt  <= '0;
      end else if (state == ST_LOAD) begin
        if (ctl.captureAddr) begin
          winRun   <= 1'b0;
          addrHeld <= 1'b1;
        end else if (ctl.commitData) begin
          winRun   <= 1'b1;
          addrHeld <= 1'b0;
          tickCnt  <= '0;
        end else if (winRun && usTick) begin
          if (tickCnt == LAST_CNT) begin
            progStart <= 1'b1;
            winRun    <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      end
    end
  end

  // R6: the start request lasts one cycle
  a_r6_start_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  // R7: a falling strobe while loading blocks the start in the next cycle
  a_r7_fall_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && wrFall && !armStart) |=> !progStart);

  // R8: arming never yields an immediate start
  a_r8_arm_no_start: assert property (@(posedge clk) disable iff (!rstN)
    armStart |=> !progStart);
endmodule

// File: rtl/pgbuf_data.sv
module pgbuf_data
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int ADDR_W     = 21
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  pgbuf_ctl_t                         ctl,
  input  logic                               armByteMode,
  input  logic [ADDR_W-1:0]                  wrAddr,
  input  logic [15:0]                        wrData,
  output logic [PAGE_BYTES*8-1:0]            pageImage,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageBase
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - IDX_W;

  logic                    byteMode;
  logic                    havePage;
  logic [ADDR_W-1:0]       latAddr;
  logic [PAGE_BYTES*8-1:0] imgReg;
  logic [IDX_W-1:0]        latIdx;
  logic [BASE_W-1:0]       latPage;
  logic                    pageOk;

  assign latIdx    = latAddr[IDX_W-1:0];
  assign latPage   = latAddr[ADDR_W-1:IDX_W];
  assign pageOk    = !havePage || (latPage == pageBase);
  assign pageImage = imgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteMode <= 1'b1;
      havePage <= 1'b0;
      latAddr  <= '0;
      pageBase <= '0;
    end else begin
      if (ctl.clearAll) begin
        byteMode <= armByteMode;
        havePage <= 1'b0;
      end else if (ctl.commitData && !havePage) begin
        havePage <= 1'b1;
        pageBase <= latPage;
      end
      if (ctl.captureAddr) latAddr <= wrAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      imgReg <= '1;
    end else if (ctl.commitData && pageOk) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (byteMode) begin
          if (latIdx == IDX_W'(b)) imgReg[b*8 +: 8] <= wrData[7:0];
        end else begin
          if (latIdx[IDX_W-1:1] == (IDX_W-1)'(b >> 1))
            imgReg[b*8 +: 8] <= (b % 2 == 0) ? wrData[7:0] : wrData[15:8];
        end
      end
    end
  end

  // R5: once a page is owned, its base only changes by re-arming
  a_r5_base_stable: assert property (@(posedge clk) disable iff (!rstN)
    (havePage && !ctl.clearAll) |=> $stable(pageBase));

  // R5: a load aimed at another page leaves the image untouched
  a_r5_foreign_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commitData && havePage && latPage != pageBase && !ctl.clearAll) |=> $stable(imgReg));
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int ADDR_W     = 21,
  parameter int TIMEOUT_US = 100
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 armStart,
  input  logic                                 armByteMode,
  input  logic                                 wrFall,
  input  logic                                 wrRise,
  input  logic [ADDR_W-1:0]                    wrAddr,
  input  logic [15:0]                          wrData,
  input  logic                                 usTick,
  output logic [PAGE_BYTES*8-1:0]              pageImage,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageBase,
  output logic                                 progStart
);
  pgbuf_ctl_t ctl;

  pgbuf_ctrl #(.TIMEOUT_US(TIMEOUT_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .armStart(armStart), .wrFall(wrFall),
    .wrRise(wrRise), .usTick(usTick), .ctl(ctl), .progStart(progStart)
  );

  pgbuf_data #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .armByteMode(armByteMode),
    .wrAddr(wrAddr), .wrData(wrData), .pageImage(pageImage), .pageBase(pageBase)
  );
endmodule

// File: tb/tb_page_load_buffer.sv
module tb_page_load_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 128;
  localparam int AW = 21;
  localparam int TO = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armStart = 1'b0, armByteMode = 1'b1, wrFall = 1'b0, wrRise = 1'b0, usTick = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [PB*8-1:0] pageImage;
  logic [AW-8:0] pageBase;
  logic progStart;

  int compared = 0, mismatched = 0, startCount = 0;
  logic [7:0] expImg [PB];
  logic [AW-8:0] expBase;
  logic expHave, expByte;

  page_load_buffer #(.PAGE_BYTES(PB), .ADDR_W(AW), .TIMEOUT_US(TO)) dut (
    .clk(clk), .rstN(rstN), .armStart(armStart), .armByteMode(armByteMode),
    .wrFall(wrFall), .wrRise(wrRise), .wrAddr(wrAddr), .wrData(wrData),
    .usTick(usTick), .pageImage(pageImage), .pageBase(pageBase), .progStart(progStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rstN && progStart) startCount++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic arm(input logic bm);
    armStart = 1'b1; armByteMode = bm; step();
    armStart = 1'b0; armByteMode = ~bm; step();   // R9: later changes must not matter
    for (int i = 0; i < PB; i++) expImg[i] = 8'hFF;
    expHave = 1'b0; expByte = bm;
  endtask

  task automatic modelLoad(input logic [AW-1:0] a, input logic [15:0] d);
    if (!expHave) begin expHave = 1'b1; expBase = a[AW-1:7]; end
    if (a[AW-1:7] == expBase) begin
      if (expByte) expImg[a[6:0]] = d[7:0];
      else begin
        expImg[{a[6:1], 1'b0}] = d[7:0];
        expImg[{a[6:1], 1'b1}] = d[15:8];
      end
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [15:0] d, input bit modelIt);
    wrAddr = a; wrFall = 1'b1; step();
    wrFall = 1'b0; wrAddr = ~a; step();           // R9: address taken at the fall
    wrData = d; wrRise = 1'b1; step();
    wrRise = 1'b0; wrData = ~d; step();           // R9: data taken at the rise
    if (modelIt) modelLoad(a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      usTick = 1'b1; step();
      usTick = 1'b0; step();
    end
  endtask

  task automatic checkImage(input string req);
    int bad = 0;
    int firstBad = -1;
    for (int i = 0; i < PB; i++)
      if (pageImage[i*8 +: 8] !== expImg[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    if (firstBad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, {24'h0, pageImage[firstBad*8 +: 8]}, {24'h0, expImg[firstBad]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int sc;
    repeat (3) step();
    rstN = 1'b1; step();

    // R1: reset state
    for (int i = 0; i < PB; i++) expImg[i] = 8'hFF;
    checkImage("R1 image after reset");
    chk(pageBase == '0, "R1 base after reset", pageBase, 0);
    chk(startCount == 0, "R1 no start after reset", startCount, 0);

    // R8: armed but no load, no timeout
    arm(1'b1);
    ticks(2 * TO);
    step();
    chk(startCount == 0, "R8 no start before first load", startCount, 0);

    // R2/R4: byte mode, every byte in reverse order, upper data byte ignored
    for (int i = PB - 1; i >= 0; i--)
      load({14'h2A3, 7'(i)}, {8'hEE, 8'(i * 7 + 3)}, 1'b1);
    checkImage("R2 byte-mode full page reverse order");
    chk(pageBase == 14'h2A3, "R5 base from first load", pageBase, 14'h2A3);

    // R5: foreign page load ignored
    load({14'h2A4, 7'd5}, 16'h0011, 1'b1);
    checkImage("R5 foreign page load ignored");
    chk(pageBase == 14'h2A3, "R5 base unchanged", pageBase, 14'h2A3);

    // R6: exact timeout boundary
    sc = startCount;
    ticks(TO - 1); step();
    chk(startCount == sc, "R6 no start before last tick", startCount, sc);
    ticks(1); step();
    chk(startCount == sc + 1, "R6 single start after last tick", startCount, sc + 1);
    ticks(TO); step();
    chk(startCount == sc + 1, "R6 no repeat start", startCount, sc + 1);

    // R6: strobes after start change nothing
    load({14'h2A3, 7'd0}, 16'h0042, 1'b0);
    checkImage("R6 load after start ignored");

    // R4/R3: rearm clears; word mode, scattered half of the words
    arm(1'b0);
    checkImage("R4 rearm refills FFh");
    for (int k = 0; k < 32; k++) begin
      int w = (k * 37) % 64;
      load({14'h01C, 6'(w), 1'(k & 1)}, {8'(w * 3 + 1), 8'(w ^ 8'h5A)}, 1'b1);
    end
    checkImage("R3 word-mode scattered loads, R4 unloaded stay FFh");
    chk(pageBase == 14'h01C, "R5 word-mode base", pageBase, 14'h01C);

    // R7: fall on the same cycle as the final tick cancels the start
    sc = startCount;
    ticks(TO - 1);
    usTick = 1'b1; wrFall = 1'b1; wrAddr = {14'h01C, 7'd2}; step();
    usTick = 1'b0; wrFall = 1'b0; wrAddr = '0; step();
    wrData = 16'hBEEF; wrRise = 1'b1; step();
    wrRise = 1'b0; step();
    modelLoad({14'h01C, 7'd2}, 16'hBEEF);
    chk(startCount == sc, "R7 fall with final tick cancels", startCount, sc);
    ticks(TO - 1); step();
    chk(startCount == sc, "R7 new window full length", startCount, sc);
    ticks(1); step();
    chk(startCount == sc + 1, "R7 start after renewed window", startCount, sc + 1);
    checkImage("R9 late load stored, word mode kept");

    // R2 in a second byte-mode page: a few loads, low edge and high edge
    arm(1'b1);
    load({14'h3FFF, 7'd0}, 16'h1234, 1'b1);
    load({14'h3FFF, 7'd127}, 16'h5678, 1'b1);
    load({14'h3FFF, 7'd64}, 16'h9A00, 1'b1);
    checkImage("R2 byte-mode edges");
    chk(pageBase == 14'h3FFF, "R5 top page base", pageBase, 14'h3FFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule